// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It is clocked by the test clock and moves through the sixteen standard test-port states under control of the mode-select input, which is sampled on each rising test-clock edge. A four-bit instruction register and a one-bit bypass register sit behind the port. Serial data enters on the data input and leaves on the data output. The output changes on the falling clock edge, and it is enabled only while one of the two shift states is active.

No dedicated test-reset pin exists. The controller is brought to its reset state by a power-on reset, or by holding the mode-select input high for five edges. An enable input stands for the fuse or disable bit that switches the port on. While the enable is low, the controller sits in its reset state, the mode-select input has no effect, and the data output stays disabled. The current state code and the active instruction are brought out so that the rest of the chip can decode them.

Top module: `scan_port_ctrl`

## Requirements
- R1: When `por` is high at a rising `tck` edge, `tap_state` becomes 0xF (Test-Logic-Reset) and `instr` becomes 0xF. After the next falling edge, `tdo` is 1 and `tdo_oe` is 0.
- R2: The state changes at each rising `tck` edge according to the standard TAP graph driven by `tms`. The state codes are: Test-Logic-Reset 0xF, Run-Test/Idle 0xC, Select-DR 0x7, Capture-DR 0x6, Shift-DR 0x2, Exit1-DR 0x1, Pause-DR 0x3, Exit2-DR 0x0, Update-DR 0x5, Select-IR 0x4, Capture-IR 0xE, Shift-IR 0xA, Exit1-IR 0x9, Pause-IR 0xB, Exit2-IR 0x8, Update-IR 0xD.
- R3: From any state, five consecutive rising edges with `tms` high leave the controller in 0xF. While in 0xF, `tms` high keeps it there.
- R4: While `en` is low, the state is held at 0xF whatever `tms` is, `instr` is 0xF and `tdo_oe` is 0. A low `en` at an edge taken in Update-IR overrides the instruction update.
- R5: Starting from Run-Test/Idle, the `tms` sequence 1, 1, 0, 0 on four consecutive rising edges ends in Shift-IR (0xA).
- R6: At the edge that leaves Capture-IR, the instruction shift stage loads 0x01. Each edge taken in Shift-IR shifts `tdi` into the shift stage, filling it from the most significant bit, so the instruction arrives least significant bit first. Bit 0 of the shift stage is presented on `tdo`, so the first four bits out are 1, 0, 0, 0.
- R7: `instr` takes the shift-stage value only at the edge taken while in Update-IR. It is reset to 0xF at an edge taken in Test-Logic-Reset. At every other edge it keeps its value.
- R8: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 exactly while the state is Shift-IR or Shift-DR. Otherwise `tdo` is 1.
- R9: Every instruction selects the one-bit bypass register. The bypass register loads 0 at the edge leaving Capture-DR and captures `tdi` at each edge taken in Shift-DR. In Shift-DR, `tdo` shows the bypass bit, which is `tdi` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| en | input | 1 | Port enable, low forces reset state |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| tap_state | output | 4 | Current state code |
| instr | output | 4 | Active instruction |

## Verification
Two actions can fall on the same rising edge: the instruction update in Update-IR and the forced reset when `en` drops. A directed case walks the controller into Update-IR with a fresh instruction and pulls `en` low on exactly that edge. The expected result is that `instr` reads 0xF rather than the shifted value. The constrained-random phase also lets enable and power-on pulses land in arbitrary states, and every cycle is compared against a bench model that gives reset priority.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'h1;
    localparam logic [IR_W-1:0] IR_BYPASS  = {IR_W{1'b1}};

    typedef enum logic [3:0] {
        ST_EXIT2_DR  = 4'h0,
        ST_EXIT1_DR  = 4'h1,
        ST_SHIFT_DR  = 4'h2,
        ST_PAUSE_DR  = 4'h3,
        ST_SEL_IR    = 4'h4,
        ST_UPDATE_DR = 4'h5,
        ST_CAPT_DR   = 4'h6,
        ST_SEL_DR    = 4'h7,
        ST_EXIT2_IR  = 4'h8,
        ST_EXIT1_IR  = 4'h9,
        ST_SHIFT_IR  = 4'hA,
        ST_PAUSE_IR  = 4'hB,
        ST_IDLE      = 4'hC,
        ST_UPDATE_IR = 4'hD,
        ST_CAPT_IR   = 4'hE,
        ST_RESET     = 4'hF
    } tap_state_t;

    // One step of the state graph for a sampled mode-select bit.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            ST_RESET:     n = m ? ST_RESET     : ST_IDLE;
            ST_IDLE:      n = m ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_DR:    n = m ? ST_SEL_IR    : ST_CAPT_DR;
            ST_CAPT_DR:   n = m ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_SHIFT_DR:  n = m ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_EXIT1_DR:  n = m ? ST_UPDATE_DR : ST_PAUSE_DR;
            ST_PAUSE_DR:  n = m ? ST_EXIT2_DR  : ST_PAUSE_DR;
            ST_EXIT2_DR:  n = m ? ST_UPDATE_DR : ST_SHIFT_DR;
            ST_UPDATE_DR: n = m ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_IR:    n = m ? ST_RESET     : ST_CAPT_IR;
            ST_CAPT_IR:   n = m ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_SHIFT_IR:  n = m ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_EXIT1_IR:  n = m ? ST_UPDATE_IR : ST_PAUSE_IR;
            ST_PAUSE_IR:  n = m ? ST_EXIT2_IR  : ST_PAUSE_IR;
            ST_EXIT2_IR:  n = m ? ST_UPDATE_IR : ST_SHIFT_IR;
            ST_UPDATE_IR: n = m ? ST_SEL_DR    : ST_IDLE;
            default:      n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic logic is_shifting(input tap_state_t s);
        return (s == ST_SHIFT_IR) || (s == ST_SHIFT_DR);
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    localparam int RESET_RUN = 5;
    localparam int RUN_W = $clog2(RESET_RUN + 1);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    // Run length of consecutive high mode-select samples, for checking only.
    logic [RUN_W-1:0] high_run;
    always_ff @(posedge clk) begin
        if (rst || !tms)                       high_run <= '0;
        else if (high_run != RUN_W'(RESET_RUN)) high_run <= high_run + 1'b1;
    end

    assert_reset_tlr_R1: assert property (@(posedge clk)
        rst |=> (state == ST_RESET));

    assert_five_high_R3: assert property (@(posedge clk) disable iff (rst)
        (high_run == RUN_W'(RESET_RUN)) |-> (state == ST_RESET));

    assert_hold_tlr_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    assert_upd_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UPDATE_IR && !tms) |=> (state == ST_IDLE));

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
#(
    parameter int              W   = IR_W,
    parameter logic [W-1:0]    CAP = W'(IR_CAPTURE)
) (
    input  logic         clk,
    input  logic         rst,
    input  tap_state_t   state,
    input  logic         tdi,
    output logic         sr_out,
    output logic [W-1:0] active
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (state == ST_CAPT_IR) begin
            sr <= CAP;
        end else if (state == ST_SHIFT_IR) begin
            sr <= {tdi, sr[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_RESET) active <= '1;
        else if (state == ST_UPDATE_IR) active <= sr;
    end

    assign sr_out = sr[0];

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPT_IR) |=> (sr == CAP));

    assert_active_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_UPDATE_IR || state == ST_RESET) |=> $stable(active));

endmodule

// File: rtl/scan_bypass.sv
module scan_bypass
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       bit_q
);

    always_ff @(posedge clk) begin
        if (rst)                       bit_q <= 1'b0;
        else if (state == ST_CAPT_DR)  bit_q <= 1'b0;
        else if (state == ST_SHIFT_DR) bit_q <= tdi;
    end

    assert_bypass_delay_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT_DR) |=> (bit_q == $past(tdi)));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            por,
    input  logic            en,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [3:0]      tap_state,
    output logic [IR_W-1:0] instr
);

    logic       rst;
    tap_state_t state;
    logic       ir_bit;
    logic       byp_bit;

    assign rst = por | ~en;

    scan_fsm u_fsm (
        .clk   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    scan_ir #(.W(IR_W), .CAP(IR_CAPTURE)) u_ir (
        .clk    (tck),
        .rst    (rst),
        .state  (state),
        .tdi    (tdi),
        .sr_out (ir_bit),
        .active (instr)
    );

    scan_bypass u_byp (
        .clk   (tck),
        .rst   (rst),
        .state (state),
        .tdi   (tdi),
        .bit_q (byp_bit)
    );

    // Output stage on the falling edge so the far end samples a settled bit.
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b1;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= is_shifting(state);
            if (state == ST_SHIFT_IR)      tdo <= ir_bit;
            else if (state == ST_SHIFT_DR) tdo <= byp_bit;
            else                           tdo <= 1'b1;
        end
    end

    assign tap_state = state;

    assert_disabled_R4: assert property (@(posedge tck) disable iff (por)
        !en |=> (instr == IR_BYPASS && state == ST_RESET));

    assert_idle_high_R8: assert property (@(posedge tck) disable iff (rst)
        !tdo_oe |-> tdo);

endmodule

// File: tb/scan_port_ctrl_test.sv
module scan_port_ctrl_test;

    logic tck = 1'b0;
    logic por, en, tms, tdi;
    logic tdo, tdo_oe;
    logic [3:0] tap_state, instr;

    always #2 tck = ~tck;

    scan_port_ctrl uut (
        .tck(tck), .por(por), .en(en), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(tap_state), .instr(instr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [3:0] m_st  = 4'hF;
    logic [3:0] m_sr  = 4'h0;
    logic       m_bp  = 1'b0;
    logic [3:0] m_act = 4'hF;
    logic       m_tdo = 1'b1;
    logic       m_oe  = 1'b0;

    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic m);
        case (s)
            4'hF: return m ? 4'hF : 4'hC;
            4'hC: return m ? 4'h7 : 4'hC;
            4'h7: return m ? 4'h4 : 4'h6;
            4'h6: return m ? 4'h1 : 4'h2;
            4'h2: return m ? 4'h1 : 4'h2;
            4'h1: return m ? 4'h5 : 4'h3;
            4'h3: return m ? 4'h0 : 4'h3;
            4'h0: return m ? 4'h5 : 4'h2;
            4'h5: return m ? 4'h7 : 4'hC;
            4'h4: return m ? 4'hF : 4'hE;
            4'hE: return m ? 4'h9 : 4'hA;
            4'hA: return m ? 4'h9 : 4'hA;
            4'h9: return m ? 4'hD : 4'hB;
            4'hB: return m ? 4'h8 : 4'hB;
            4'h8: return m ? 4'hD : 4'hA;
            default: return m ? 4'h7 : 4'hC; // 4'hD
        endcase
    endfunction

    task automatic check4(input string req, input string what,
                          input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic t_ms, input logic t_di, input logic t_en,
                        input logic t_por, input string req);
        logic r;
        logic [3:0] o_st, o_sr;
        string dreq;
        por = t_por; en = t_en; tms = t_ms; tdi = t_di;
        @(posedge tck);
        r = t_por | ~t_en;
        o_st = m_st; o_sr = m_sr;
        if (r) begin
            m_st = 4'hF; m_sr = 4'h0; m_bp = 1'b0; m_act = 4'hF;
        end else begin
            if (o_st == 4'hF)      m_act = 4'hF;
            else if (o_st == 4'hD) m_act = o_sr;
            if (o_st == 4'hE)      m_sr = 4'h1;
            else if (o_st == 4'hA) m_sr = {t_di, o_sr[3:1]};
            if (o_st == 4'h6)      m_bp = 1'b0;
            else if (o_st == 4'h2) m_bp = t_di;
            m_st = ref_next(o_st, t_ms);
        end
        #1;
        check4(req, "state", tap_state, m_st);
        check4(req, "instr", instr, m_act);
        @(negedge tck);
        if (r) begin
            m_tdo = 1'b1; m_oe = 1'b0;
        end else begin
            m_oe  = (m_st == 4'hA) || (m_st == 4'h2);
            m_tdo = (m_st == 4'hA) ? m_sr[0] : (m_st == 4'h2) ? m_bp : 1'b1;
        end
        #1;
        dreq = (req == "R6" || req == "R9" || req == "R1") ? req : "R8";
        check4(dreq, "tdo", {3'b0, tdo}, {3'b0, m_tdo});
        check4(dreq, "tdo_oe", {3'b0, tdo_oe}, {3'b0, m_oe});
    endtask

    task automatic five_high(input string req);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, 1'b0, req);
        check4(req, "state after five high", tap_state, 4'hF);
    endtask

    initial begin
        fork
            begin
                #(200000 * 4);
                if (!done) begin
                    fails++;
                    $display("FAIL watchdog expired");
                    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [3:0] code;
        void'($urandom(32'd20240611));
        por = 1'b1; en = 1'b1; tms = 1'b0; tdi = 1'b0;
        @(negedge tck); #1;

        // R1: power-on reset
        step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
        check4("R1", "reset state", tap_state, 4'hF);
        check4("R1", "reset instr", instr, 4'hF);

        // R2 / R5: into Run-Test/Idle then 1,1,0,0 to Shift-IR
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        check4("R2", "idle", tap_state, 4'hC);
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        check4("R5", "shift-ir reached", tap_state, 4'hA);

        // R6: shift 0x5 least significant bit first, capture 0x01 comes out
        code = 4'h5;
        for (int i = 0; i < 4; i++)
            step((i == 3), code[i], 1'b1, 1'b0, "R6");
        check4("R6", "exit1-ir", tap_state, 4'h9);

        // R7: update only in Update-IR
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        check4("R7", "instr before update", instr, 4'hF);
        step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
        check4("R7", "instr after update", instr, 4'h5);

        // R9: bypass capture and one-clock delay
        step(1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R9");

        // R3: five high from a DR-side state
        five_high("R3");

        // R4: enable drops on the edge taken in Update-IR
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step((i == 3), 1'b0, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        check4("R4", "in update-ir", tap_state, 4'hD);
        step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        check4("R4", "update overridden", instr, 4'hF);
        for (int i = 0; i < 4; i++) step(i[0], 1'b1, 1'b0, 1'b0, "R4");
        check4("R4", "held while disabled", tap_state, 4'hF);
        check4("R4", "oe while disabled", {3'b0, tdo_oe}, 4'h0);

        // Constrained random walk against the model
        for (int i = 0; i < 4000; i++) begin
            logic rt, rd, re, rp;
            rt = ($urandom % 3) == 0;
            rd = $urandom % 2;
            re = ($urandom % 60) != 0;
            rp = ($urandom % 250) == 0;
            step(rt, rd, re, rp, "R2");
        end
        five_high("R3");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule